// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small associative record of loads that a compiler has hoisted above earlier stores. When such an advanced load executes, the table records which destination register it filled, the byte address it read and how many bytes it read. Every later store is compared against all recorded entries, and any entry whose byte range the store touches is dropped, because the hoisted load may have read stale data.

When the program reaches the point where the load originally stood, a check operation looks up the destination register number. A surviving entry means the early load is still good and execution goes on. A missing entry means a conflicting store may have intervened, and the pipeline must branch to recovery code that redoes the load. The table has two independent search ports over the same entries: one keyed by register number (for checks and for finding an entry to reuse on a new load), and one by address range (for stores).

Top module: `spec_ld_table`

## Requirements
- R1: After reset, or in the cycle after `flush_i` is high, every check misses; a load presented in the same cycle as a flush is not recorded.
- R2: A load presented with `ld_valid_i` creates an entry, so that a check of its register number in any later cycle hits while no overlapping store has occurred.
- R3: A check compares register numbers only. With `chk_valid_i` high exactly one of `chk_hit_o` (entry found) and `chk_recover_o` (no entry) is high; with `chk_valid_i` low both are low.
- R4: A store removes an entry when the byte ranges [addr, addr+bytes) of the store and of the entry share at least one byte. The 2-bit size code gives the bytes: 0 means 1, 1 means 2, 2 means 4, 3 means 8.
- R5: A store whose range only borders an entry's range, on either side, leaves that entry in place.
- R6: A load to a register that already has an entry replaces that entry's address and size, so the old range is no longer tracked, and no register ever owns two entries.
- R7: A load to a new register takes the lowest-numbered free entry when one exists, and evicts nothing.
- R8: When all entries are valid, a load to a new register evicts the entry selected by a rotating pointer; the pointer starts at entry 0 after reset and moves up by one, wrapping, on each such eviction only.
- R9: When a load and a store arrive in the same cycle, the store is applied first and the new entry is written afterwards, so the new entry survives even if it overlaps the store.
- R10: A check reports the table as it stood at the start of the cycle; a load, store or flush in the same cycle affects only checks in later cycles.
- R11: A single store removes every entry it overlaps, not only the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| ld_valid_i | input | 1 | Advanced load present |
| ld_reg_i | input | REG_W | Destination register number of the load |
| ld_addr_i | input | ADDR_W | Byte address of the load |
| ld_size_i | input | 2 | Size code of the load |
| st_valid_i | input | 1 | Store present |
| st_addr_i | input | ADDR_W | Byte address of the store |
| st_size_i | input | 2 | Size code of the store |
| chk_valid_i | input | 1 | Check present |
| chk_reg_i | input | REG_W | Register number to look up |
| chk_hit_o | output | 1 | Entry found, speculation stands |
| chk_recover_o | output | 1 | No entry, branch to recovery |

## Verification
The assertions take the control inputs to be known, 0 or 1, at every clock edge after reset, and take the address, register and size fields to be known whenever their valid bit is high. They also assume that no register number is held by two entries, which only the load path could break. The stimulus changes inputs one nanosecond after a rising edge and clears every valid bit after each operation. Checks are placed at the falling edge, so state only changes through the defined ports. All addresses used stay far below the top of the address space, and every register set up for a test is first cleared by a flush or placed at an unused address so that earlier entries cannot disturb the results.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;

   typedef enum logic [1:0] {
      SZ_B1 = 2'd0,
      SZ_B2 = 2'd1,
      SZ_B4 = 2'd2,
      SZ_B8 = 2'd3
   } acc_size_e;

   // Byte count covered by an access of the given size code.
   function automatic logic [3:0] size_bytes(input acc_size_e code);
      return 4'd1 << code;
   endfunction

endpackage

// File: rtl/sld_range_cmp.sv
module sld_range_cmp
   import spec_ld_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] a_base_i,
   input  acc_size_e         a_size_i,
   input  logic [ADDR_W-1:0] b_base_i,
   input  acc_size_e         b_size_i,
   output logic              overlap_o
);
   // One extra bit keeps the end of a range from wrapping to zero.
   localparam int EXT_W = ADDR_W + 1;

   logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

   always_comb begin
      a_lo = {1'b0, a_base_i};
      b_lo = {1'b0, b_base_i};
      a_hi = a_lo + EXT_W'(size_bytes(a_size_i));
      b_hi = b_lo + EXT_W'(size_bytes(b_size_i));
      // Half-open intervals intersect when each starts before the other ends.
      overlap_o = (a_lo < b_hi) && (b_lo < a_hi);
   end

endmodule

// File: rtl/sld_reg_search.sv
module sld_reg_search #(
   parameter int ENTRIES = 16,
   parameter int REG_W   = 7
) (
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [REG_W-1:0]   regs_i [ENTRIES],
   input  logic [REG_W-1:0]   key_i,
   output logic [ENTRIES-1:0] match_o
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
      assign match_o[e] = valid_i[e] && (regs_i[e] == key_i);
   end
endmodule

// File: rtl/sld_alloc.sv
module sld_alloc #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_i,
   input  logic [ENTRIES-1:0] owner_i,
   input  logic [ENTRIES-1:0] valid_post_i,
   output logic [IDX_W-1:0]   idx_o,
   output logic               evict_o
);
   localparam bit POW2 = ((1 << IDX_W) == ENTRIES);

   logic [IDX_W-1:0] ptr_q, ptr_nxt, owner_idx, free_idx;
   logic             has_owner, has_free;

   always_comb begin
      has_owner = |owner_i;
      has_free  = ~&valid_post_i;
      owner_idx = '0;
      free_idx  = '0;
      // Descending scan leaves the lowest matching index.
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (owner_i[i])       owner_idx = IDX_W'(i);
         if (!valid_post_i[i]) free_idx  = IDX_W'(i);
      end
      if (has_owner)     idx_o = owner_idx;
      else if (has_free) idx_o = free_idx;
      else               idx_o = ptr_q;
      evict_o = req_i && !has_owner && !has_free;
   end

   if (POW2) begin : g_wrap
      assign ptr_nxt = ptr_q + 1'b1;
   end else begin : g_cmp
      assign ptr_nxt = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (evict_o) ptr_q <= ptr_nxt;
   end

   // R8: the victim pointer never names a missing entry.
   a_r8_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr_q) < ENTRIES);

   // R8: the pointer moves only when a victim is taken.
   a_r8_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !evict_o |=> $stable(ptr_q));

endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
   import spec_ld_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int ADDR_W  = 32,
   parameter int REG_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              ld_valid_i,
   input  logic [REG_W-1:0]  ld_reg_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [1:0]        ld_size_i,
   input  logic              st_valid_i,
   input  logic [ADDR_W-1:0] st_addr_i,
   input  logic [1:0]        st_size_i,
   input  logic              chk_valid_i,
   input  logic [REG_W-1:0]  chk_reg_i,
   output logic              chk_hit_o,
   output logic              chk_recover_o
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   initial begin
      assert (ENTRIES >= 2 && ENTRIES <= 256)
         else $error("spec_ld_table: ENTRIES out of range");
      assert (ADDR_W >= 4 && ADDR_W <= 64)
         else $error("spec_ld_table: ADDR_W out of range");
      assert (REG_W >= 1 && REG_W <= 16)
         else $error("spec_ld_table: REG_W out of range");
   end

   logic [ENTRIES-1:0] valid_q, valid_d, valid_post, kill_vec, overlap;
   logic [ENTRIES-1:0] ld_match, chk_match;
   logic [REG_W-1:0]   reg_q  [ENTRIES];
   logic [ADDR_W-1:0]  addr_q [ENTRIES];
   acc_size_e          size_q [ENTRIES];
   logic [IDX_W-1:0]   wr_idx;
   logic               evict;
   logic               ld_take;

   assign ld_take = ld_valid_i && !flush_i;

   // Address port: every entry compares its range with the store.
   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      sld_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .a_base_i (addr_q[e]),
         .a_size_i (size_q[e]),
         .b_base_i (st_addr_i),
         .b_size_i (acc_size_e'(st_size_i)),
         .overlap_o(overlap[e])
      );
      assign kill_vec[e] = st_valid_i && valid_q[e] && overlap[e];
   end

   assign valid_post = valid_q & ~kill_vec;

   // Register port for the load path: find an entry to reuse.
   sld_reg_search #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_ld_search (
      .valid_i(valid_q),
      .regs_i (reg_q),
      .key_i  (ld_reg_i),
      .match_o(ld_match)
   );

   // Register port for checks.
   sld_reg_search #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_chk_search (
      .valid_i(valid_q),
      .regs_i (reg_q),
      .key_i  (chk_reg_i),
      .match_o(chk_match)
   );

   sld_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (ld_take),
      .owner_i     (ld_match),
      .valid_post_i(valid_post),
      .idx_o       (wr_idx),
      .evict_o     (evict)
   );

   // Store first, then the new entry on top of the result.
   always_comb begin
      valid_d = valid_post;
      if (ld_take) valid_d[wr_idx] = 1'b1;
      if (flush_i) valid_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else        valid_q <= valid_d;
   end

   always_ff @(posedge clk) begin
      if (ld_take) begin
         reg_q[wr_idx]  <= ld_reg_i;
         addr_q[wr_idx] <= ld_addr_i;
         size_q[wr_idx] <= acc_size_e'(ld_size_i);
      end
   end

   assign chk_hit_o     = chk_valid_i && (|chk_match);
   assign chk_recover_o = chk_valid_i && !(|chk_match);

   // R1: a flush leaves no entry behind.
   a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (valid_q == '0));

   // R2 and R9: the written entry holds the load even with a store alongside.
   a_r2_install_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ld_take |=> (valid_q[$past(wr_idx)] && (reg_q[$past(wr_idx)] == $past(ld_reg_i))));

   // R4: every entry the store overlapped is gone afterwards.
   a_r4_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid_i && !flush_i && !ld_valid_i) |=> ((valid_q & $past(kill_vec)) == '0));

   // R6: a register is never owned by more than one entry.
   a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid_i |-> ($countones(ld_match) <= 1));

   // R10: a hit requires a recorded entry.
   a_r10_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
      chk_hit_o |-> (valid_q != '0));

   // R8: an eviction happens only in a cycle with a load.
   a_r8_evict_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      evict |-> ld_valid_i);

endmodule

// File: tb/test_spec_ld_table.sv
`timescale 1ns/1ps
module test_spec_ld_table;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic        ld_valid_i = 1'b0;
   logic [6:0]  ld_reg_i = '0;
   logic [31:0] ld_addr_i = '0;
   logic [1:0]  ld_size_i = '0;
   logic        st_valid_i = 1'b0;
   logic [31:0] st_addr_i = '0;
   logic [1:0]  st_size_i = '0;
   logic        chk_valid_i = 1'b0;
   logic [6:0]  chk_reg_i = '0;
   logic        chk_hit_o, chk_recover_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   spec_ld_table i_spec_ld_table (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .ld_valid_i(ld_valid_i), .ld_reg_i(ld_reg_i), .ld_addr_i(ld_addr_i), .ld_size_i(ld_size_i),
      .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
      .chk_valid_i(chk_valid_i), .chk_reg_i(chk_reg_i),
      .chk_hit_o(chk_hit_o), .chk_recover_o(chk_recover_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
      ld_valid_i = 1'b0;
      st_valid_i = 1'b0;
      flush_i    = 1'b0;
   endtask

   task automatic set_load(input logic [6:0] r, input logic [31:0] a, input logic [1:0] s);
      ld_valid_i = 1'b1; ld_reg_i = r; ld_addr_i = a; ld_size_i = s;
   endtask

   task automatic set_store(input logic [31:0] a, input logic [1:0] s);
      st_valid_i = 1'b1; st_addr_i = a; st_size_i = s;
   endtask

   task automatic load(input logic [6:0] r, input logic [31:0] a, input logic [1:0] s);
      set_load(r, a, s);
      tick();
   endtask

   task automatic store(input logic [31:0] a, input logic [1:0] s);
      set_store(a, s);
      tick();
   endtask

   task automatic flush();
      flush_i = 1'b1;
      tick();
   endtask

   // Probe at the falling edge; a check never changes state.
   task automatic probe(input logic [6:0] r, input logic exp_hit, input string tag);
      @(negedge clk);
      chk_valid_i = 1'b1;
      chk_reg_i   = r;
      #1;
      checks++;
      if (chk_hit_o !== exp_hit || chk_recover_o !== !exp_hit) begin
         errors++;
         $display("FAIL %s reg %0d: hit=%b recover=%b, expected hit=%b recover=%b",
                  tag, r, chk_hit_o, chk_recover_o, exp_hit, !exp_hit);
      end
      chk_valid_i = 1'b0;
   endtask

   task automatic t_reset();
      probe(7'd0, 1'b0, "R1 reset");
      probe(7'd5, 1'b0, "R1 reset");
      probe(7'd127, 1'b0, "R1 reset");
      @(negedge clk);
      #1;
      checks++;
      if (chk_hit_o !== 1'b0 || chk_recover_o !== 1'b0) begin
         errors++;
         $display("FAIL R3 idle: hit=%b recover=%b, expected 0 0", chk_hit_o, chk_recover_o);
      end
   endtask

   task automatic t_install();
      load(7'd5, 32'h100, 2'd3);
      probe(7'd5, 1'b1, "R2 install");
      probe(7'd6, 1'b0, "R3 other register");
   endtask

   task automatic t_same_cycle_check();
      @(posedge clk); #1;
      set_load(7'd9, 32'h900, 2'd0);
      probe(7'd9, 1'b0, "R10 same-cycle check");
      tick();
      probe(7'd9, 1'b1, "R10 next-cycle check");
   endtask

   task automatic t_overlap();
      load(7'd10, 32'h200, 2'd2);           // bytes 0x200..0x203
      store(32'h203, 2'd0);                 // last byte
      probe(7'd10, 1'b0, "R4 last byte");
      load(7'd10, 32'h200, 2'd2);
      store(32'h204, 2'd3);                 // starts right after
      probe(7'd10, 1'b1, "R5 border above");
      store(32'h1FC, 2'd2);                 // ends right before
      probe(7'd10, 1'b1, "R5 border below");
      store(32'h1FE, 2'd1);
      probe(7'd10, 1'b1, "R5 two bytes below");
      store(32'h1FF, 2'd1);                 // 0x1FF..0x200
      probe(7'd10, 1'b0, "R4 straddle low edge");
   endtask

   task automatic t_multi_kill();
      load(7'd1, 32'h300, 2'd3);
      load(7'd2, 32'h304, 2'd2);
      load(7'd3, 32'h310, 2'd0);
      store(32'h300, 2'd3);
      probe(7'd1, 1'b0, "R11 first overlapped");
      probe(7'd2, 1'b0, "R11 second overlapped");
      probe(7'd3, 1'b1, "R11 untouched");
   endtask

   task automatic t_overwrite();
      load(7'd20, 32'h400, 2'd0);
      load(7'd20, 32'h500, 2'd0);
      store(32'h400, 2'd0);
      probe(7'd20, 1'b1, "R6 old range dropped");
      store(32'h500, 2'd0);
      probe(7'd20, 1'b0, "R6 new range tracked");
   endtask

   task automatic t_load_store_same_cycle();
      load(7'd41, 32'h604, 2'd0);
      set_load(7'd40, 32'h600, 2'd3);
      set_store(32'h600, 2'd3);
      tick();
      probe(7'd40, 1'b1, "R9 new entry survives");
      probe(7'd41, 1'b0, "R9 old entry killed");
   endtask

   task automatic t_flush();
      load(7'd30, 32'h700, 2'd0);
      set_load(7'd31, 32'h710, 2'd0);
      flush();
      probe(7'd30, 1'b0, "R1 flush");
      probe(7'd31, 1'b0, "R1 load during flush");
      probe(7'd40, 1'b0, "R1 flush");
   endtask

   task automatic t_replace();
      for (int i = 0; i < 16; i++) load(7'(i), 32'h1000 + 32'(i) * 32'h10, 2'd0);
      for (int i = 0; i < 16; i++) probe(7'(i), 1'b1, "R7 fill");
      load(7'd16, 32'h2000, 2'd0);          // full: evicts entry 0 (reg 0)
      probe(7'd0, 1'b0, "R8 first victim");
      for (int i = 1; i < 17; i++) probe(7'(i), 1'b1, "R8 survivors");
      load(7'd17, 32'h2010, 2'd0);          // evicts entry 1 (reg 1)
      probe(7'd1, 1'b0, "R8 second victim");
      store(32'h1050, 2'd0);                // frees entry 5 (reg 5)
      load(7'd18, 32'h2020, 2'd0);          // uses entry 5, no eviction
      probe(7'd2, 1'b1, "R7 no eviction");
      probe(7'd18, 1'b1, "R7 free slot");
      load(7'd19, 32'h2030, 2'd0);          // evicts entry 2 (reg 2)
      probe(7'd2, 1'b0, "R8 pointer held over free fill");
      probe(7'd3, 1'b1, "R8 next in line kept");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_install();
      t_same_cycle_check();
      t_overlap();
      t_multi_kill();
      t_overwrite();
      t_load_store_same_cycle();
      t_flush();
      t_replace();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule